// File: doc/BRIEF.md
# Standby-Retained Pin Pull Control

This block is a small APB slave holding two per-pin control words for one 16-pin port. One word requests pull-ups and the other requests pull-downs. Each pin's request reaches the pad side only while two enable flags, one from each of two CPU power domains, are both high. When a pin requests both pulls, the pull-down wins and the pull-up stays off. The stored words survive the reset that is issued when the system leaves standby. Only the power-on reset clears them.

The bus side is a plain APB completer. PREADY is the only back-pressure. Every access is stretched by a fixed number of wait cycles, with writes taking longer than reads. The requester must hold PADDR, PWRITE and PWDATA stable from the setup phase until it samples PREADY high. Register state changes only at the edge where PREADY is high. The pull outputs are registered, so they follow the stored bits and the enable flags one clock later.

Top module: `stby_pull_regs`

## Requirements
- R1: After power-on reset (`presetn` low), both pull outputs are 0 and both registers read as 0x0000_0000.
- R2: A write keeps PREADY low for exactly 3 access-phase cycles and raises it on the 4th.
- R3: A read keeps PREADY low for exactly 2 access-phase cycles and raises it on the 3rd.
- R4: The pull-up word is at byte offset 0x028 and the pull-down word is at 0x02C. Bit n controls pin n. A read returns the last value written in bits 15:0, and bits 31:16 always read 0 whatever was driven on the bus.
- R5: An access to any other offset, including a misaligned one, uses the same wait count as its direction. It raises PSLVERR together with PREADY, returns 0 and changes no register or output.
- R6: Pull-down output bit n is 1 only when pull-down bit n is set and both domain enables are high. Pull-up output bit n is 1 only when pull-up bit n is set, pull-down bit n is clear and both domain enables are high.
- R7: A pin with both its pull-up bit and its pull-down bit set drives its pull-down output 1 and its pull-up output 0.
- R8: Holding `stby_rst_n` low leaves both registers and both outputs unchanged.
- R9: The outputs change at the first clock edge after the edge on which a write completes, or after the edge on which a changed enable level is sampled. They do not change earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Power-on reset, active low, asynchronous |
| stby_rst_n | input | 1 | Standby-exit reset, active low; clears only the bus wait logic |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 16 | Write data lanes carrying pin bits (upper lanes not connected) |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Unmapped offset |
| dom_a_en | input | 1 | Pull enable flag from domain A |
| dom_b_en | input | 1 | Pull enable flag from domain B |
| pu_en_o | output | 16 | Per-pin pull-up enables |
| pd_en_o | output | 16 | Per-pin pull-down enables |

## Verification
A write can complete on the same clock edge at which a domain enable flag changes level. The bench provokes this by switching the flags in the cycle where PREADY is already high. It then checks that, one edge later, the outputs reflect both the new stored bits and the new flag levels. The standby-exit reset is also held low over stored non-zero contents, and the outputs and readbacks are judged against the values written before it.

// File: rtl/stby_pull_pkg.sv
package stby_pull_pkg;
  localparam int unsigned BUS_DW = 32;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PU   = 2'd1,
    SEL_PD   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/apb_wait_ctrl.sv
module apb_wait_ctrl #(
  parameter int unsigned WR_WAIT = 3,
  parameter int unsigned RD_WAIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_rst_n,
  input  logic access,
  input  logic is_wr,
  output logic ready
);
  localparam int unsigned MAXW  = (WR_WAIT > RD_WAIT) ? WR_WAIT : RD_WAIT;
  localparam int unsigned CNT_W = (MAXW < 1) ? 1 : $clog2(MAXW + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;

  assign target = is_wr ? CNT_W'(WR_WAIT) : CNT_W'(RD_WAIT);
  assign ready  = access && (cnt_q == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!stby_rst_n)     cnt_q <= '0;
    else if (access && !ready) cnt_q <= cnt_q + 1'b1;
    else                      cnt_q <= '0;
  end
endmodule

// File: rtl/pull_reg_file.sv
module pull_reg_file
  import stby_pull_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PINS   = 16,
  parameter logic [ADDR_W-1:0] PU_OFS = 'h028,
  parameter logic [ADDR_W-1:0] PD_OFS = 'h02C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              addr_err,
  output logic [PINS-1:0]   pu_q,
  output logic [PINS-1:0]   pd_q
);
  reg_sel_e        sel;
  logic [PINS-1:0] rd_pins;

  always_comb begin
    if (addr == PU_OFS)      sel = SEL_PU;
    else if (addr == PD_OFS) sel = SEL_PD;
    else                     sel = SEL_NONE;
  end

  assign addr_err = (sel == SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_q <= '0;
      pd_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_PU) pu_q <= wdata;
      if (sel == SEL_PD) pd_q <= wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_PU:  rd_pins = pu_q;
      SEL_PD:  rd_pins = pd_q;
      default: rd_pins = '0;
    endcase
  end

  assign rdata = DATA_W'(rd_pins);
endmodule

// File: rtl/pull_out_gate.sv
module pull_out_gate #(
  parameter int unsigned PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pu_q,
  input  logic [PINS-1:0] pd_q,
  input  logic            en_a,
  input  logic            en_b,
  output logic [PINS-1:0] pu_o,
  output logic [PINS-1:0] pd_o
);
  logic both_en;
  assign both_en = en_a & en_b;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pu_o[p] <= 1'b0;
        pd_o[p] <= 1'b0;
      end else begin
        pd_o[p] <= both_en & pd_q[p];
        pu_o[p] <= both_en & pu_q[p] & ~pd_q[p];
      end
    end
  end
endmodule

// File: rtl/stby_pull_regs.sv
module stby_pull_regs #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = stby_pull_pkg::BUS_DW,
  parameter int unsigned PINS    = 16,
  parameter int unsigned WR_WAIT = 3,
  parameter int unsigned RD_WAIT = 2,
  parameter logic [ADDR_W-1:0] PU_OFS = 'h028,
  parameter logic [ADDR_W-1:0] PD_OFS = 'h02C
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              stby_rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [PINS-1:0]   pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              dom_a_en,
  input  logic              dom_b_en,
  output logic [PINS-1:0]   pu_en_o,
  output logic [PINS-1:0]   pd_en_o
);
  logic              access;
  logic              done;
  logic              addr_err;
  logic [DATA_W-1:0] rdata;
  logic [PINS-1:0]   pu_q;
  logic [PINS-1:0]   pd_q;

  assign access = psel & penable;
  assign done   = access & pready;

  apb_wait_ctrl #(.WR_WAIT(WR_WAIT), .RD_WAIT(RD_WAIT)) u_wait (
    .clk(pclk), .rst_n(presetn), .stby_rst_n(stby_rst_n),
    .access(access), .is_wr(pwrite), .ready(pready)
  );

  pull_reg_file #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PINS(PINS),
    .PU_OFS(PU_OFS), .PD_OFS(PD_OFS)
  ) u_regs (
    .clk(pclk), .rst_n(presetn),
    .wr_en(done & pwrite & ~addr_err),
    .addr(paddr), .wdata(pwdata),
    .rdata(rdata), .addr_err(addr_err),
    .pu_q(pu_q), .pd_q(pd_q)
  );

  pull_out_gate #(.PINS(PINS)) u_gate (
    .clk(pclk), .rst_n(presetn),
    .pu_q(pu_q), .pd_q(pd_q),
    .en_a(dom_a_en), .en_b(dom_b_en),
    .pu_o(pu_en_o), .pd_o(pd_en_o)
  );

  assign pslverr = done & addr_err;
  assign prdata  = (done & ~pwrite & ~addr_err) ? rdata : '0;
endmodule

// File: rtl/stby_pull_chk.sv
module stby_pull_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PINS    = 16,
  parameter int unsigned WR_WAIT = 3,
  parameter int unsigned RD_WAIT = 2
) (
  input logic              pclk,
  input logic              presetn,
  input logic              stby_rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic              dom_a_en,
  input logic              dom_b_en,
  input logic [PINS-1:0]   pu_en_o,
  input logic [PINS-1:0]   pd_en_o
);
  int unsigned lo_cnt;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)                              lo_cnt <= 0;
    else if (!stby_rst_n)                      lo_cnt <= 0;
    else if (psel && penable && !pready)       lo_cnt <= lo_cnt + 1;
    else                                       lo_cnt <= 0;
  end

  assert_wr_wait_R2: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && pready) |-> (lo_cnt == WR_WAIT));

  assert_rd_wait_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && pready) |-> (lo_cnt == RD_WAIT));

  assert_rsvd_zero_R4: assert property (@(posedge pclk) disable iff (!presetn)
    prdata[DATA_W-1:PINS] == '0);

  assert_err_clean_R5: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> (pready && psel && penable && prdata == '0));

  assert_gate_off_R6: assert property (@(posedge pclk) disable iff (!presetn)
    !(dom_a_en && dom_b_en) |=> (pu_en_o == '0 && pd_en_o == '0));

  assert_pd_wins_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (pu_en_o & pd_en_o) == '0);
endmodule

bind stby_pull_regs stby_pull_chk #(
  .DATA_W(DATA_W), .PINS(PINS), .WR_WAIT(WR_WAIT), .RD_WAIT(RD_WAIT)
) u_chk (
  .pclk(pclk), .presetn(presetn), .stby_rst_n(stby_rst_n),
  .psel(psel), .penable(penable), .pwrite(pwrite),
  .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .dom_a_en(dom_a_en), .dom_b_en(dom_b_en),
  .pu_en_o(pu_en_o), .pd_en_o(pd_en_o)
);

// File: tb/test_stby_pull_regs.sv
module test_stby_pull_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_PU = 12'h028;
  localparam logic [11:0] A_PD = 12'h02C;

  // {pu, pd, en_a, en_b, exp_pu, exp_pd}
  localparam logic [65:0] VECS [7] = '{
    {16'hFFFF, 16'h0000, 1'b1, 1'b1, 16'hFFFF, 16'h0000},
    {16'h00FF, 16'h0F0F, 1'b1, 1'b1, 16'h00F0, 16'h0F0F},
    {16'hA5A5, 16'h5A5A, 1'b0, 1'b1, 16'h0000, 16'h0000},
    {16'hA5A5, 16'h5A5A, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {16'hA5A5, 16'h5A5A, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {16'hA5A5, 16'h5A5A, 1'b1, 1'b1, 16'hA5A5, 16'h5A5A},
    {16'h1234, 16'h1230, 1'b1, 1'b1, 16'h0004, 16'h1230}
  };

  logic clk = 0, presetn = 0, stby_rst_n = 1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [15:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic dom_a_en = 0, dom_b_en = 0;
  logic [15:0] pu_en_o, pd_en_o;

  int total = 0, bad = 0;
  logic [31:0] rd;
  int waits;
  logic err;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_pull_regs i_stby_pull_regs (
    .pclk(clk), .presetn(presetn), .stby_rst_n(stby_rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr),
    .dom_a_en(dom_a_en), .dom_b_en(dom_b_en),
    .pu_en_o(pu_en_o), .pd_en_o(pd_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [11:0] addr, input logic [15:0] data,
                      input logic flip, input logic na, input logic nb);
    @(negedge clk);
    psel = 1; pwrite = wr; paddr = addr; pwdata = data; penable = 0;
    @(negedge clk);
    penable = 1; #1;
    waits = 0;
    while (!pready) begin
      waits++;
      @(negedge clk); #1;
    end
    rd = prdata; err = pslverr;
    if (flip) begin dom_a_en = na; dom_b_en = nb; end
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    presetn = 1;
    @(negedge clk);
    chk("R1 pu out", 32'(pu_en_o), 0);
    chk("R1 pd out", 32'(pd_en_o), 0);
    xfer(0, A_PU, 0, 0, 0, 0);
    chk("R1 pu read", rd, 0);
    chk("R3 read waits", waits, 2);
    xfer(0, A_PD, 0, 0, 0, 0);
    chk("R1 pd read", rd, 0);

    xfer(1, A_PU, 16'h1234, 0, 0, 0);
    chk("R2 write waits", waits, 3);
    chk("R2 write no err", 32'(err), 0);
    xfer(0, A_PU, 0, 0, 0, 0);
    chk("R4 pu readback", rd, 32'h0000_1234);

    foreach (VECS[i]) begin
      xfer(1, A_PU, VECS[i][65:50], 0, 0, 0);
      xfer(1, A_PD, VECS[i][49:34], 0, 0, 0);
      @(negedge clk);
      dom_a_en = VECS[i][33]; dom_b_en = VECS[i][32];
      settle();
      chk("R6 pu gate", 32'(pu_en_o), 32'(VECS[i][31:16]));
      chk("R6/R7 pd gate", 32'(pd_en_o), 32'(VECS[i][15:0]));
      xfer(0, A_PD, 0, 0, 0, 0);
      chk("R4 pd readback", rd, 32'(VECS[i][49:34]));
    end

    // R7 all pins request both pulls
    xfer(1, A_PU, 16'hFFFF, 0, 0, 0);
    xfer(1, A_PD, 16'hFFFF, 0, 0, 0);
    settle();
    chk("R7 pu off", 32'(pu_en_o), 0);
    chk("R7 pd on", 32'(pd_en_o), 32'h0000_FFFF);

    // R9 output timing
    xfer(1, A_PD, 16'h0000, 0, 0, 0);
    xfer(1, A_PU, 16'h0000, 0, 0, 0);
    settle();
    xfer(1, A_PU, 16'h8000, 0, 0, 0);
    chk("R9 not yet", 32'(pu_en_o), 0);
    @(negedge clk);
    chk("R9 one edge later", 32'(pu_en_o), 32'h0000_8000);
    dom_b_en = 0;
    chk("R9 enable not yet", 32'(pu_en_o), 32'h0000_8000);
    @(negedge clk);
    chk("R9 enable drop", 32'(pu_en_o), 0);
    dom_b_en = 1;
    settle();

    // R5 unmapped and misaligned offsets
    xfer(1, 12'h030, 16'hFFFF, 0, 0, 0);
    chk("R5 wr err", 32'(err), 1);
    chk("R5 wr waits", waits, 3);
    xfer(1, 12'h029, 16'h00FF, 0, 0, 0);
    chk("R5 misaligned err", 32'(err), 1);
    xfer(0, 12'h030, 0, 0, 0, 0);
    chk("R5 rd err", 32'(err), 1);
    chk("R5 rd data", rd, 0);
    chk("R5 rd waits", waits, 2);
    xfer(0, A_PU, 0, 0, 0, 0);
    chk("R5 pu untouched", rd, 32'h0000_8000);
    xfer(0, A_PD, 0, 0, 0, 0);
    chk("R5 pd untouched", rd, 0);
    chk("R5 out untouched", 32'(pu_en_o), 32'h0000_8000);

    // R8 standby-exit reset retains state
    xfer(1, A_PU, 16'h00F0, 0, 0, 0);
    xfer(1, A_PD, 16'h0F00, 0, 0, 0);
    settle();
    @(negedge clk); stby_rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 pu out held", 32'(pu_en_o), 32'h0000_00F0);
    chk("R8 pd out held", 32'(pd_en_o), 32'h0000_0F00);
    stby_rst_n = 1;
    xfer(0, A_PU, 0, 0, 0, 0);
    chk("R8 pu kept", rd, 32'h0000_00F0);
    xfer(0, A_PD, 0, 0, 0, 0);
    chk("R8 pd kept", rd, 32'h0000_0F00);

    // write completing on the same edge as an enable change
    @(negedge clk); dom_a_en = 0;
    settle();
    chk("R6 gated off", 32'(pd_en_o), 0);
    xfer(1, A_PU, 16'h0003, 1, 1, 1);
    @(negedge clk);
    chk("R9 joint pu", 32'(pu_en_o), 32'h0000_0003);
    chk("R9 joint pd", 32'(pd_en_o), 32'h0000_0F00);

    // R1 power-on reset clears contents
    @(negedge clk); presetn = 0;
    @(negedge clk); presetn = 1;
    chk("R1 por pu out", 32'(pu_en_o), 0);
    xfer(0, A_PU, 0, 0, 0, 0);
    chk("R1 por pu read", rd, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule